// File: doc/BRIEF.md
# Receive Data-Ready Interrupt and Timeout

This block decides when a serial receiver should raise its data-ready interrupt to the host. It watches the fill level of the receive buffer and compares it against a programmed trigger level. When buffering is switched off, a single received character is enough to raise the interrupt. When buffering is on, the interrupt follows the trigger comparison.

A timeout path covers the case where a few characters arrive and then the line goes quiet below the trigger level. A counter advances on each bit-time tick. Once the count reaches four character frames plus twelve spare bit times, a timeout flag sets and raises the interrupt. The frame length follows the configured data width.

Any received character or host read restarts the count. An empty buffer, or disabling the buffer, clears the count and the flag. The buffer storage itself sits outside this block.

Top module: `rx_ready_irq`

## Requirements
- R1: With `fifo_en` low, `irq` equals `irq_en` whenever `fill_lvl` is non-zero, in the same cycle, and the timeout flag never sets.
- R2: With `fifo_en` high, the level part of the interrupt is true exactly while `fill_lvl` is non-zero and `fill_lvl >= trig_lvl`. It drops in the same cycle that `fill_lvl` falls below `trig_lvl`.
- R3: With `fifo_en` high, `fill_lvl` non-zero and below `trig_lvl`, `tmo_flag` rises after the N-th `bit_tick` counted since the last restart, where N = 32 + 4*`wlen_code`. This gives 32, 36, 40 and 44 for codes 0 to 3, which select 5 to 8 data bits.
- R4: A cycle with `char_strobe` or `host_rd` high resets the tick count to zero. A tick in that same cycle is not counted.
- R5: `irq` = `irq_en` AND (level condition OR `tmo_flag`). `tmo_flag` itself is not gated by `irq_en`.
- R6: A cycle with `host_rd` high clears `tmo_flag` at the next clock edge.
- R7: A cycle with `fill_lvl` zero or `fifo_en` low clears `tmo_flag` and the tick count at the next edge.
- R8: After reset `tmo_flag` is 0.
- R9: Ticks that arrive while the level is at or above the trigger still count, up to N-1 and no further. If the level then falls below the trigger, the next tick sets `tmo_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Buffering enabled |
| irq_en | input | 1 | Data-ready interrupt enable |
| trig_lvl | input | LVL_W | Programmed trigger level |
| wlen_code | input | 2 | Data width code, 0 = 5 bits to 3 = 8 bits |
| fill_lvl | input | LVL_W | Bytes currently held in the receive buffer |
| char_strobe | input | 1 | One-cycle pulse per received character |
| host_rd | input | 1 | One-cycle pulse per host read of a byte |
| bit_tick | input | 1 | One pulse per bit time |
| irq | output | 1 | Data-ready interrupt |
| tmo_flag | output | 1 | Timeout is the pending source |

## Verification
A count that is off by one shows as `tmo_flag` rising one tick early or late. The bench catches this by stepping every data width code with a tick on every cycle and checking the flag just before and just after tick N. A count that fails to restart or clear would raise a spurious timeout within at most 44 ticks of quiet line. The random phase therefore keeps long quiet stretches and compares both outputs against a bench model on every cycle. Level errors appear on `irq` in the same cycle, because the comparison is combinational.

// File: rtl/rx_ready_irq.sv
module rx_ready_irq #(
  parameter int LVL_W = 9,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             irq_en,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic [1:0]       wlen_code,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic             char_strobe,
  input  logic             host_rd,
  input  logic             bit_tick,
  output logic             irq,
  output logic             tmo_flag
);
  localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(31);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             have_data, below, armed, restart, level_hit;

  assign have_data = fill_lvl != '0;
  assign below     = fill_lvl < trig_lvl;
  assign armed     = fifo_en && have_data;
  assign restart   = char_strobe || host_rd;
  assign lim_m1    = BASE_M1 + CNT_W'({wlen_code, 2'b00});
  assign level_hit = have_data && (!fifo_en || !below);
  assign irq       = irq_en && (level_hit || tmo_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tmo_flag <= 1'b0;
    end else if (!armed || restart) begin
      cnt      <= '0;
      tmo_flag <= 1'b0;
    end else if (bit_tick && !tmo_flag) begin
      if (cnt >= lim_m1) begin
        cnt <= lim_m1;
        if (below) begin
          tmo_flag <= 1'b1;
          cnt      <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) host_rd |=> !tmo_flag); // R6
  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !armed |=> !tmo_flag); // R7
  AST_NOFIFO_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n) !fifo_en |=> !tmo_flag); // R1
  AST_TMO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(tmo_flag) |-> $past(bit_tick && below && !restart)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(44)); // R9
endmodule

// File: tb/rx_ready_irq_bench.sv
module rx_ready_irq_bench;
  localparam int LW = 9;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, irq_en = 0, char_strobe = 0, host_rd = 0, bit_tick = 0;
  logic [LW-1:0] trig_lvl = 0, fill_lvl = 0;
  logic [1:0] wlen_code = 0;
  logic irq, tmo_flag;
  int checks = 0, fails = 0;
  int m_cnt = 0;
  bit m_tmo = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_ready_irq u_rx_ready_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .irq_en(irq_en),
    .trig_lvl(trig_lvl), .wlen_code(wlen_code), .fill_lvl(fill_lvl),
    .char_strobe(char_strobe), .host_rd(host_rd), .bit_tick(bit_tick),
    .irq(irq), .tmo_flag(tmo_flag));

  function automatic int lim(input logic [1:0] c);
    return 32 + 4 * int'(c);
  endfunction

  function automatic bit exp_irq();
    bit lvl = (fill_lvl != 0) && (!fifo_en || fill_lvl >= trig_lvl);
    return irq_en && (lvl || m_tmo);
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit armed = fifo_en && fill_lvl != 0;
    bit below = fill_lvl < trig_lvl;
    if (!armed || char_strobe || host_rd) begin
      m_cnt = 0; m_tmo = 0;
    end else if (bit_tick && !m_tmo) begin
      if (m_cnt >= lim(wlen_code) - 1) begin
        m_cnt = lim(wlen_code) - 1;
        if (below) begin m_tmo = 1; m_cnt = 0; end
      end else m_cnt++;
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1 model_step();
    @(negedge clk);
    chk("R3", tmo_flag, m_tmo);
    chk("R2", irq, exp_irq());
  endtask

  task automatic idle_in();
    char_strobe = 0; host_rd = 0; bit_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R8", tmo_flag, 1'b0);
    rst_n = 1;
    // R1: non-FIFO mode, one character raises irq
    irq_en = 1; fill_lvl = 1; cyc();
    chk("R1", irq, 1'b1);
    bit_tick = 1; repeat (60) cyc();
    chk("R1", tmo_flag, 1'b0);
    irq_en = 0; cyc();
    chk("R5", irq, 1'b0);
    irq_en = 1; fill_lvl = 0; bit_tick = 0; cyc();
    chk("R1", irq, 1'b0);
    // R3 exact length per code, R6 read clear
    fifo_en = 1; trig_lvl = 8;
    for (int c = 0; c < 4; c++) begin
      wlen_code = 2'(c); fill_lvl = 0; idle_in(); cyc();
      fill_lvl = 3; bit_tick = 1;
      repeat (lim(2'(c)) - 1) cyc();
      chk("R3", tmo_flag, 1'b0);
      cyc();
      chk("R3", tmo_flag, 1'b1);
      chk("R5", irq, 1'b1);
      bit_tick = 0; host_rd = 1; cyc();
      chk("R6", tmo_flag, 1'b0);
      host_rd = 0;
    end
    // R4 restart by char
    wlen_code = 0; bit_tick = 1;
    repeat (20) cyc();
    char_strobe = 1; cyc(); char_strobe = 0;
    repeat (31) cyc();
    chk("R4", tmo_flag, 1'b0);
    cyc();
    chk("R4", tmo_flag, 1'b1);
    irq_en = 0; cyc();
    chk("R5", tmo_flag, 1'b1);
    chk("R5", irq, 1'b0);
    irq_en = 1;
    // R7 empty clears
    fill_lvl = 0; bit_tick = 0; cyc();
    chk("R7", tmo_flag, 1'b0);
    // R9 saturation at/above trigger, R2 level
    fill_lvl = 8; bit_tick = 1; repeat (50) cyc();
    chk("R2", irq, 1'b1);
    chk("R9", tmo_flag, 1'b0);
    fill_lvl = 7; bit_tick = 0; #1;
    chk("R2", irq, 1'b0);
    bit_tick = 1; cyc();
    chk("R9", tmo_flag, 1'b1);
    fifo_en = 0; fill_lvl = 1; bit_tick = 0; cyc();
    chk("R7", tmo_flag, 1'b0);
    // random phase
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 199) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 299) == 0) irq_en = ~irq_en;
      if ($urandom_range(0, 499) == 0) wlen_code = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 499) == 0) trig_lvl = LW'($urandom_range(1, 16));
      char_strobe = ($urandom_range(0, 119) == 0);
      host_rd = ($urandom_range(0, 119) == 0);
      bit_tick = ($urandom_range(0, 1) == 0);
      if (char_strobe && fill_lvl < 20) fill_lvl++;
      if (host_rd && fill_lvl != 0) fill_lvl--;
      cyc();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule